// File: doc/BRIEF.md
# Deserializer Output Enable and Lock Controller

This block decides, for every parallel output of a multi-lane deserializer, whether that output is high-impedance, held low, or passing received data. It bases the decision on a power enable input, a lock timer, a detector for clock activity, and idle flags from the line receivers. The recovered clock output has its own enable and hold-low controls. The pad drivers apply these controls, and the PLL and the analog idle sensing sit outside the block.

Everything runs on a free-running reference clock. The incoming parallel-rate clock is treated as data. It passes through a two-flop synchronizer, and its rising edges are detected in the reference domain. Those edges drive two counters. One counts edges within a fixed reference window to judge whether the input clock is alive. The other counts edges after enable and declares lock at a fixed count.

The power enable has two paths. The falling edge reaches the output enables combinationally, so the pads release the bus at once. The rising edge only takes effect after a two-flop synchronizer. Because of this, two instances whose outputs share one bus as a 2:1 mux can hand over without overlap.

Top module: `dsr_out_ctrl`

## Requirements
- R1: While `pwr_on` is 0, `data_oe` is all zeros and `clkout_oe` is 0 in the same cycle, with no clock edge needed. `locked` is 0 from the third reference edge after `pwr_on` falls.
- R2: `pwr_on` is sampled at reference edge j. The enables become 1 after edge j+1. Until `locked` is 1, every bit of `data_force_low` is 1 and `clkout_force_low` is 1.
- R3: A rising edge of `in_clk` sampled at reference edge k is counted at edge k+2. It is counted only while the synchronized enable is 1 and the clock is marked active. `locked` becomes 1 on the edge that counts the LOCK_CYCLES-th rising edge.
- R4: Windows of WINDOW reference cycles run back to back from reset. At the last edge of each window, the clock is marked active if the window counted at least `min_edges` rising edges, and inactive otherwise. The mark changes at no other edge. While the clock is inactive, the lock count restarts from zero, `locked` is 0, and every enabled output is forced low.
- R5: In plain mode (`balanced`=0), with the block locked and the clock active, `lane_idle[i]`=1 forces only `data_force_low[i]`.
- R6: In plain mode, `clk_idle`=1 forces every data lane and the clock output low.
- R7: In balanced mode (`balanced`=1), `lane_idle` and `clk_idle` have no effect on any force-low output.
- R8: A force-low output is never 1 while its enable is 0.
- R9: Consider two instances whose enables are never both 1 at once, with a handover made by dropping one enable and raising the other in the same cycle. Their output enables are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_on | input | 1 | Power enable; 0 places all outputs in high impedance |
| in_clk | input | 1 | Received parallel-rate clock, sampled as data |
| balanced | input | 1 | 1 selects balanced coding mode, where idle forcing is disabled |
| clk_idle | input | 1 | Clock lane receiver reports an idle line |
| lane_idle | input | LANES | Per data lane receiver idle flags |
| min_edges | input | EDGE_W | Minimum rising edges per window for an active clock |
| data_oe | output | LANES | Per-lane output enable |
| data_force_low | output | LANES | Per-lane hold-low control |
| clkout_oe | output | 1 | Clock output enable |
| clkout_force_low | output | 1 | Clock output hold-low control |
| locked | output | 1 | Lock declared |

## Verification
The bench builds the block with LANES=3, LOCK_CYCLES=20 and WINDOW=32, so lock takes about a hundred cycles instead of tens of thousands. At these values, several lock, unlock and relock sequences fit within one run. With `min_edges`=4, an input clock of four reference cycles per period gives eight edges per window and counts as active. A period of sixteen reference cycles gives two edges and is judged too slow, and a stopped clock is also covered. A second instance shares the bus with the first and shows that the handover causes no overlap.

// File: rtl/dsr_out_pkg.sv
package dsr_out_pkg;

  // Edge count after one more cycle, saturating at the register limit.
  function automatic int edge_add(int cnt, bit rise, int limit);
    int n;
    n = cnt + (rise ? 1 : 0);
    return (n > limit) ? limit : n;
  endfunction

  // Verdict at the end of a window: enough edges seen, including this one.
  function automatic bit window_pass(int cnt, bit rise, int min_n);
    return (cnt + (rise ? 1 : 0)) >= min_n;
  endfunction

  // Hold-low decision for one enabled output.
  function automatic bit need_low(bit locked, bit active, bit balanced, bit idle);
    return !locked || !active || (!balanced && idle);
  endfunction

endpackage

// File: rtl/dsr_sync.sv
module dsr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dsr_act_mon.sv
module dsr_act_mon #(
  parameter int WINDOW = 64,
  parameter int EDGE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise,
  input  logic [EDGE_W-1:0] min_edges,
  output logic              active,
  output logic              win_end
);
  localparam int WIN_W = (WINDOW > 2) ? $clog2(WINDOW) : 1;
  localparam int EDGE_MAX = (1 << EDGE_W) - 1;

  logic [WIN_W-1:0]  win_cnt;
  logic [EDGE_W-1:0] edge_cnt;

  assign win_end = (win_cnt == WIN_W'(WINDOW - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt  <= '0;
      edge_cnt <= '0;
      active   <= 1'b0;
    end else if (win_end) begin
      win_cnt  <= '0;
      edge_cnt <= '0;
      active   <= dsr_out_pkg::window_pass(int'(edge_cnt), rise, int'(min_edges));
    end else begin
      win_cnt  <= win_cnt + 1'b1;
      edge_cnt <= EDGE_W'(dsr_out_pkg::edge_add(int'(edge_cnt), rise, EDGE_MAX));
    end
  end
endmodule

// File: rtl/dsr_lock_timer.sv
module dsr_lock_timer #(
  parameter int LOCK_CYCLES = 32800
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic rise,
  output logic locked,
  output logic lock_hit
);
  localparam int CW = $clog2(LOCK_CYCLES + 1);

  logic [CW-1:0] cnt;

  assign lock_hit = run && !locked && rise && (cnt == CW'(LOCK_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      locked <= 1'b0;
    end else if (!run) begin
      cnt    <= '0;
      locked <= 1'b0;
    end else if (!locked && rise) begin
      cnt <= cnt + 1'b1;
      if (lock_hit) locked <= 1'b1;
    end
  end
endmodule

// File: rtl/dsr_out_ctrl.sv
module dsr_out_ctrl #(
  parameter int LANES       = 3,
  parameter int LOCK_CYCLES = 32800,
  parameter int WINDOW      = 64,
  localparam int EDGE_W     = $clog2(WINDOW + 1)
) (
  input  logic              ref_clk,
  input  logic              rst_n,
  input  logic              pwr_on,
  input  logic              in_clk,
  input  logic              balanced,
  input  logic              clk_idle,
  input  logic [LANES-1:0]  lane_idle,
  input  logic [EDGE_W-1:0] min_edges,
  output logic [LANES-1:0]  data_oe,
  output logic [LANES-1:0]  data_force_low,
  output logic              clkout_oe,
  output logic              clkout_force_low,
  output logic              locked
);
  // Named internal events, visible to the bound checker.
  logic pwr_ok;
  logic in_s;
  logic in_prev;
  logic in_rise;
  logic clk_active;
  logic win_end;
  logic lock_hit;
  logic drive_en;

  dsr_sync #(.STAGES(2)) u_pwr_sync (
    .clk(ref_clk), .rst_n(rst_n), .d(pwr_on), .q(pwr_ok)
  );

  dsr_sync #(.STAGES(2)) u_clk_sync (
    .clk(ref_clk), .rst_n(rst_n), .d(in_clk), .q(in_s)
  );

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) in_prev <= 1'b0;
    else        in_prev <= in_s;
  end

  assign in_rise = in_s & ~in_prev;

  dsr_act_mon #(.WINDOW(WINDOW), .EDGE_W(EDGE_W)) u_act (
    .clk(ref_clk), .rst_n(rst_n), .rise(in_rise), .min_edges(min_edges),
    .active(clk_active), .win_end(win_end)
  );

  dsr_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk(ref_clk), .rst_n(rst_n), .run(pwr_ok & clk_active), .rise(in_rise),
    .locked(locked), .lock_hit(lock_hit)
  );

  // Falling enable acts at once; rising enable waits for the synchronizer.
  assign drive_en  = pwr_on & pwr_ok;
  assign clkout_oe = drive_en;
  assign clkout_force_low = drive_en &
    dsr_out_pkg::need_low(locked, clk_active, balanced, clk_idle);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign data_oe[l]        = drive_en;
    assign data_force_low[l] = drive_en &
      dsr_out_pkg::need_low(locked, clk_active, balanced, clk_idle | lane_idle[l]);
  end
endmodule

// File: rtl/dsr_out_ctrl_chk.sv
module dsr_out_ctrl_chk #(
  parameter int LANES = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwr_on,
  input logic             pwr_ok,
  input logic             clk_active,
  input logic             win_end,
  input logic             lock_hit,
  input logic             balanced,
  input logic             clk_idle,
  input logic [LANES-1:0] data_oe,
  input logic [LANES-1:0] data_force_low,
  input logic             clkout_oe,
  input logic             clkout_force_low,
  input logic             locked
);
  // R1: enable low means every output is released
  p_hiz_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |-> (data_oe == '0) && !clkout_oe);

  // R1: synchronized enable low clears lock on the next edge
  p_off_clears_lock_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> !locked);

  // R2: driven but not locked means everything is held low
  p_low_until_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clkout_oe && !locked) |-> (&data_force_low) && clkout_force_low);

  // R3: lock is declared only by the terminal count, with power and clock good
  p_lock_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lock_hit |=> locked);
  p_lock_needs_good_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(clk_active) && $past(pwr_ok));

  // R4: activity verdict moves only at a window end; inactive drops lock
  p_verdict_at_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> $stable(clk_active));
  p_inactive_unlocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_active |=> !locked);

  // R6: plain mode clock idle holds everything low
  p_clk_idle_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!balanced && clk_idle && clkout_oe) |-> (&data_force_low) && clkout_force_low);

  // R7: balanced mode, locked and active, nothing held low
  p_balanced_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (balanced && locked && clk_active && clkout_oe) |->
      (data_force_low == '0) && !clkout_force_low);

  // R8: no hold-low on a released output
  p_no_force_on_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((data_force_low & ~data_oe) == '0) && !(clkout_force_low && !clkout_oe));
endmodule

bind dsr_out_ctrl dsr_out_ctrl_chk #(.LANES(LANES)) u_chk (
  .clk(ref_clk), .rst_n(rst_n), .pwr_on(pwr_on), .pwr_ok(pwr_ok),
  .clk_active(clk_active), .win_end(win_end), .lock_hit(lock_hit),
  .balanced(balanced), .clk_idle(clk_idle), .data_oe(data_oe),
  .data_force_low(data_force_low), .clkout_oe(clkout_oe),
  .clkout_force_low(clkout_force_low), .locked(locked)
);

// R9: two instances sharing one output bus never drive it together
module dsr_bus_share_chk (
  input logic clk,
  input logic rst_n,
  input logic oe_a,
  input logic oe_b
);
  p_one_driver_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(oe_a && oe_b));
endmodule

// File: tb/test_dsr_out_ctrl.sv
module test_dsr_out_ctrl;
  localparam int LANES = 3;
  localparam int LOCKN = 20;
  localparam int WIN   = 32;
  localparam int EW    = $clog2(WIN + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic pwr_on = 1'b0, pwr_b = 1'b0, in_clk = 1'b0;
  logic balanced = 1'b0, clk_idle = 1'b0;
  logic [LANES-1:0] lane_idle = '0;
  logic [EW-1:0] min_edges = EW'(4);

  logic [LANES-1:0] data_oe, data_fl, b_data_oe, b_data_fl;
  logic clk_oe, clk_fl, locked, b_clk_oe, b_clk_fl, b_locked;

  always #4 clk = ~clk;  // 125 MHz

  dsr_out_ctrl #(.LANES(LANES), .LOCK_CYCLES(LOCKN), .WINDOW(WIN)) i_dsr_out_ctrl (
    .ref_clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .in_clk(in_clk),
    .balanced(balanced), .clk_idle(clk_idle), .lane_idle(lane_idle),
    .min_edges(min_edges), .data_oe(data_oe), .data_force_low(data_fl),
    .clkout_oe(clk_oe), .clkout_force_low(clk_fl), .locked(locked));

  dsr_out_ctrl #(.LANES(LANES), .LOCK_CYCLES(LOCKN), .WINDOW(WIN)) i_dsr_out_ctrl_b (
    .ref_clk(clk), .rst_n(rst_n), .pwr_on(pwr_b), .in_clk(in_clk),
    .balanced(balanced), .clk_idle(clk_idle), .lane_idle(lane_idle),
    .min_edges(min_edges), .data_oe(b_data_oe), .data_force_low(b_data_fl),
    .clkout_oe(b_clk_oe), .clkout_force_low(b_clk_fl), .locked(b_locked));

  dsr_bus_share_chk i_share (.clk(clk), .rst_n(rst_n), .oe_a(clk_oe), .oe_b(b_clk_oe));

  int errors = 0, checks = 0;
  bit done = 0;

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Input clock source: toggles every 'half' reference cycles while running.
  int  half = 2;
  bit  run  = 0;
  int  hc   = 0;
  always @(negedge clk) begin
    if (run) begin
      hc++;
      if (hc >= half) begin
        in_clk = ~in_clk;
        hc = 0;
      end
    end
  end

  // Behavioural reference: sample histories, window tally, lock tally.
  bit ih[$];
  bit ph[$];
  int win_n, edge_n, lock_n;
  bit m_act, m_lock, m_rise, m_pok, m_oe;
  logic [LANES-1:0] m_fl;
  bit m_cfl;
  string tag;

  always @(posedge clk) begin
    if (!rst_n) begin
      ih = '{0, 0, 0};
      ph = '{0, 0};
      win_n = 0; edge_n = 0; lock_n = 0; m_act = 0; m_lock = 0;
    end else begin
      m_rise = ih[1] && !ih[2];
      m_pok  = ph[1];
      if (!m_pok || !m_act) begin
        lock_n = 0; m_lock = 0;
      end else if (!m_lock && m_rise) begin
        lock_n++;
        if (lock_n == LOCKN) m_lock = 1;
      end
      if (win_n == WIN - 1) begin
        m_act  = (edge_n + (m_rise ? 1 : 0)) >= int'(min_edges);
        edge_n = 0; win_n = 0;
      end else begin
        edge_n += m_rise ? 1 : 0;
        win_n++;
      end
      ih.push_front(in_clk); void'(ih.pop_back());
      ph.push_front(pwr_on); void'(ph.pop_back());
    end
    #2;
    if (!done) begin
      m_oe  = ph[1] && pwr_on;
      m_cfl = m_oe && (!m_lock || !m_act || (!balanced && clk_idle));
      for (int l = 0; l < LANES; l++)
        m_fl[l] = m_oe && (!m_lock || !m_act || (!balanced && (clk_idle || lane_idle[l])));
      if (!pwr_on)        tag = "R1";
      else if (!m_oe)     tag = "R2";
      else if (!m_act)    tag = "R4";
      else if (!m_lock)   tag = "R3";
      else if (balanced)  tag = "R7";
      else if (clk_idle)  tag = "R6";
      else                tag = "R5";
      check(data_oe == {LANES{m_oe}} && clk_oe == m_oe, {tag, " oe"},
            {data_oe, clk_oe}, {{LANES{m_oe}}, m_oe});
      check(data_fl == m_fl, {tag, " lane force"}, data_fl, m_fl);
      check(clk_fl == m_cfl, {tag, " clock force"}, clk_fl, m_cfl);
      check(locked == m_lock, {tag, " locked"}, locked, m_lock);
      check(!(clk_oe && b_clk_oe), "R9 shared bus", {clk_oe, b_clk_oe}, 2'b00);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    cyc(5);
    #1;
    check(data_oe == '0 && !clk_oe && !locked, "R1 reset state", {data_oe, clk_oe, locked}, 0);
    @(negedge clk) rst_n = 1'b1;
    run = 1; half = 2;
    cyc(3);
    pwr_on = 1'b1;
    cyc(1); #1;
    check(data_oe == '0, "R2 enable waits for synchronizer", data_oe, 0);
    cyc(1); #1;
    check(clk_oe && data_oe == '1 && data_fl == '1 && clk_fl, "R2 driven low before lock",
          {data_oe, data_fl, clk_fl}, {3'b111, 3'b111, 1'b1});
    cyc(200); #1;
    check(locked && data_fl == '0 && !clk_fl, "R3 lock releases outputs",
          {locked, data_fl, clk_fl}, {1'b1, 3'b000, 1'b0});

    @(negedge clk) lane_idle = 3'b010;
    #1;
    check(data_fl == 3'b010 && !clk_fl, "R5 single lane idle", {data_fl, clk_fl}, {3'b010, 1'b0});
    @(negedge clk) lane_idle = 3'b101;
    #1;
    check(data_fl == 3'b101, "R5 two lanes idle", data_fl, 3'b101);
    @(negedge clk) begin lane_idle = '0; clk_idle = 1'b1; end
    #1;
    check(data_fl == '1 && clk_fl, "R6 clock idle forces all", {data_fl, clk_fl}, {3'b111, 1'b1});
    @(negedge clk) begin balanced = 1'b1; lane_idle = '1; end
    #1;
    check(data_fl == '0 && !clk_fl, "R7 balanced ignores idle", {data_fl, clk_fl}, 0);
    cyc(10);
    @(negedge clk) begin balanced = 1'b0; lane_idle = '0; clk_idle = 1'b0; end

    // Too slow: two edges per window against a minimum of four.
    half = 8;
    cyc(90); #1;
    check(!locked && data_fl == '1 && clk_fl, "R4 slow clock forces low",
          {locked, data_fl, clk_fl}, {1'b0, 3'b111, 1'b1});
    half = 2;
    cyc(200); #1;
    check(locked, "R3 relock after clock recovers", locked, 1);
    run = 0;
    cyc(80); #1;
    check(!locked && clk_fl, "R4 stopped clock forces low", {locked, clk_fl}, 2'b01);
    run = 1;
    cyc(200); #1;
    check(locked, "R3 relock after restart", locked, 1);

    // Immediate release and bus handover to the second instance.
    @(negedge clk) begin pwr_on = 1'b0; pwr_b = 1'b1; end
    #1;
    check(data_oe == '0 && !clk_oe, "R1 immediate release", {data_oe, clk_oe}, 0);
    check(data_fl == '0 && !clk_fl, "R8 no force while released", {data_fl, clk_fl}, 0);
    cyc(3); #1;
    check(!locked, "R1 lock cleared", locked, 0);
    check(b_clk_oe && !clk_oe, "R9 handover to second instance", {clk_oe, b_clk_oe}, 2'b01);
    cyc(20);
    @(negedge clk) begin pwr_b = 1'b0; pwr_on = 1'b1; end
    cyc(3); #1;
    check(clk_oe && !b_clk_oe, "R9 handover back", {clk_oe, b_clk_oe}, 2'b10);
    cyc(10);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule